// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Each word is 9 bits wide, and the depth is a power of two set by a parameter. Four active-low status flags report the fill level. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The almost flags compare the fill level against two offsets. Both offsets default to 7 words and can be reloaded.

One input pin has two possible roles, and its level during reset decides which one it takes until the next reset. If the pin is high during reset, it is a second write enable. If it is low during reset, it is a load strobe for the two threshold offsets. Pointers cross between the clock domains in Gray code through two-flop synchronizers.

Back-pressure works in the usual stream manner:
- `full_n` acts as the write-side ready.
- `empty_n` acts as the read-side valid.
- A request made while the matching flag is low is dropped, not queued.

The offsets are only reloaded while traffic is stopped, so the read domain can use them as static values.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers return to the first location. `empty_n` and `aempty_n` are low, and `full_n` and `afull_n` are high. After reset the FIFO holds no data.
- R2: The mode is taken from `wr_en2_ld` on write-clock edges while `rst_n` is low. A high level gives dual-enable mode and a low level gives load mode. The mode does not change while `rst_n` stays high.
- R3: In dual-enable mode, a word is stored on a rising `wr_clk` edge only when `wr_en1_n` is low and `wr_en2_ld` is high. With `wr_en2_ld` low, nothing is stored.
- R4: In load mode, each edge with `wr_en1_n` low and `wr_en2_ld` low loads `wr_data[AW-1:0]` into an offset register and stores no data. The loads go almost-empty, then almost-full, then back to almost-empty. An edge with `wr_en1_n` low and `wr_en2_ld` high stores data.
- R5: A write attempted while `full_n` is low is ignored, and the stored contents stay unchanged.
- R6: A read happens on a rising `rd_clk` edge only when `rd_en1_n` and `rd_en2_n` are both low and `empty_n` is high. A read attempted while empty leaves the output word unchanged.
- R7: Words leave in the order they were written, with nothing lost or duplicated, under any mix of clock ratio and request pattern. The word appears on the output one read-clock edge after the read.
- R8: Once the pointers have settled, `aempty_n` is low exactly when the fill level is at or below the almost-empty offset. The default offset is 7.
- R9: Once the pointers have settled, `afull_n` is low exactly when the fill level is at or above depth minus the almost-full offset. The default offset is 7.
- R10: A flag asserts on the same edge as the operation in its own domain that causes it. A flag may stay asserted for the synchronizer latency, but it never reads inactive when its condition holds. Full implies almost-full, and empty implies almost-empty.
- R11: With `out_en_n` high, `rd_data` is all zero and `rd_data_en` is low. With `out_en_n` low, `rd_data_en` is high and `rd_data` shows the last word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable or offset-load strobe; role sampled during reset |
| wr_data | input | DW | Write word; low AW bits carry an offset during loads |
| full_n | output | 1 | Full flag, active low, write clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |
| rd_clk | input | 1 | Read clock |
| rd_en1_n | input | 1 | Read enable 1, active low |
| rd_en2_n | input | 1 | Read enable 2, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | DW | Last word read, zero while disabled |
| rd_data_en | output | 1 | High while the output word is driven |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |

## Verification
The failure modes show up at the ports in different ways:
- A corrupted pointer or a bad Gray conversion shows up as a wrong or repeated word on `rd_data`, one read-clock edge after the read that consumes it.
- A flag that wrongly reads inactive is caught on the next clock of its own domain. At that clock, the reference queue already holds no entry (for empty) or holds a full depth of entries (for full).
- A wrong threshold, a wrong offset-load order or a wrong mode capture only appears once both synchronizers have settled. Each fill level is therefore checked after a short idle period in both domains.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    WM_DUAL = 1'b0,
    WM_LOAD = 1'b1
  } wr_mode_e;

  typedef enum logic {
    LS_AEMPTY = 1'b0,
    LS_AFULL  = 1'b1
  } ld_sel_e;
endpackage

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_ptr_xing.sv
module dcf_ptr_xing #(
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_gray,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= src_gray;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    dst_bin[PW-1] = stg[STAGES-1][PW-1];
    for (int i = PW-2; i >= 0; i--) dst_bin[i] = dst_bin[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DW      = 9,
  parameter int AW      = 4,
  parameter int DEF_OFS = 7
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rptr_bin,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic [AW-1:0] ae_ofs
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

  wr_mode_e      mode_q;
  ld_sel_e       ld_sel_q;
  logic [PW-1:0] wptr_q, wgray_q, wptr_nx, fill_nx;
  logic [AW-1:0] ae_ofs_q, af_ofs_q;
  logic          full_n_q, afull_n_q;
  logic          wr_req, ld_req, wr_fire;

  // role of the shared pin is captured only while reset is held
  always_ff @(posedge wr_clk) begin
    if (!rst_n) mode_q <= wr_en2_ld ? WM_DUAL : WM_LOAD;
  end

  assign wr_req  = !wr_en1_n && wr_en2_ld;
  assign ld_req  = (mode_q == WM_LOAD) && !wr_en1_n && !wr_en2_ld;
  assign wr_fire = wr_req && full_n_q;
  assign wptr_nx = wptr_q + PW'(wr_fire);
  assign fill_nx = wptr_nx - rptr_bin;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
      ae_ofs_q  <= AW'(DEF_OFS);
      af_ofs_q  <= AW'(DEF_OFS);
      ld_sel_q  <= LS_AEMPTY;
    end else begin
      wptr_q    <= wptr_nx;
      wgray_q   <= wptr_nx ^ (wptr_nx >> 1);
      full_n_q  <= (fill_nx != DEPTH_V);
      afull_n_q <= (fill_nx < (DEPTH_V - {1'b0, af_ofs_q}));
      if (ld_req) begin
        if (ld_sel_q == LS_AEMPTY) begin
          ae_ofs_q <= wr_data[AW-1:0];
          ld_sel_q <= LS_AFULL;
        end else begin
          af_ofs_q <= wr_data[AW-1:0];
          ld_sel_q <= LS_AEMPTY;
        end
      end
    end
  end

  assign mem_we    = wr_fire;
  assign mem_waddr = wptr_q[AW-1:0];
  assign wgray     = wgray_q;
  assign full_n    = full_n_q;
  assign afull_n   = afull_n_q;
  assign ae_ofs    = ae_ofs_q;

  // R5: no pointer movement while full
  a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n_q |=> wptr_q == $past(wptr_q));
  // R4: an offset load never stores data
  a_r4_load_no_data: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ld_req |=> wptr_q == $past(wptr_q));
  // R2: captured mode is frozen once reset has been released
  a_r2_mode_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
  // R10: full implies almost-full
  a_r10_full_afull: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n_q |-> !afull_n_q);
  // R7: published pointer changes at most one bit per edge
  a_r7_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic [AW:0]   wptr_bin,
  input  logic [AW-1:0] ae_ofs,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_q,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_q, rgray_q, rptr_nx, fill_nx;
  logic [DW-1:0] rd_q_r;
  logic          empty_n_q, aempty_n_q, rd_fire;

  assign rd_fire = !rd_en1_n && !rd_en2_n && empty_n_q;
  assign rptr_nx = rptr_q + PW'(rd_fire);
  assign fill_nx = wptr_bin - rptr_nx;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q     <= '0;
      rgray_q    <= '0;
      rd_q_r     <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rptr_q     <= rptr_nx;
      rgray_q    <= rptr_nx ^ (rptr_nx >> 1);
      empty_n_q  <= (fill_nx != '0);
      aempty_n_q <= (fill_nx > {1'b0, ae_ofs});
      if (rd_fire) rd_q_r <= mem_rdata;
    end
  end

  assign mem_raddr = rptr_q[AW-1:0];
  assign rgray     = rgray_q;
  assign rd_q      = rd_q_r;
  assign empty_n   = empty_n_q;
  assign aempty_n  = aempty_n_q;

  // R6: no pointer movement or output change while empty
  a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n_q |=> (rptr_q == $past(rptr_q)) && $stable(rd_q_r));
  // R10: empty implies almost-empty
  a_r10_empty_aempty: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n_q |-> !aempty_n_q);
  // R7: published pointer changes at most one bit per edge
  a_r7_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcf_pflag_fifo.sv
module dcf_pflag_fifo #(
  parameter int DW      = 9,
  parameter int AW      = 4,
  parameter int DEF_OFS = 7,
  parameter int SYNC_N  = 2
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld,
  input  logic [DW-1:0] wr_data,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rd_clk,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_en,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW = AW + 1;

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr, ae_ofs;
  logic [DW-1:0] mem_rdata, rd_q;
  logic [PW-1:0] wgray, rgray, wptr_in_rd, rptr_in_wr;

  dcf_wr_ctl #(.DW(DW), .AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .wr_data(wr_data), .rptr_bin(rptr_in_wr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n), .ae_ofs(ae_ofs));

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata));

  dcf_ptr_xing #(.PW(PW), .STAGES(SYNC_N)) u_w2r (
    .dst_clk(rd_clk), .rst_n(rst_n), .src_gray(wgray), .dst_bin(wptr_in_rd));

  dcf_ptr_xing #(.PW(PW), .STAGES(SYNC_N)) u_r2w (
    .dst_clk(wr_clk), .rst_n(rst_n), .src_gray(rgray), .dst_bin(rptr_in_wr));

  dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .wptr_bin(wptr_in_rd), .ae_ofs(ae_ofs), .mem_rdata(mem_rdata),
    .mem_raddr(mem_raddr), .rgray(rgray), .rd_q(rd_q),
    .empty_n(empty_n), .aempty_n(aempty_n));

  assign rd_data_en = !out_en_n;
  assign rd_data    = out_en_n ? '0 : rd_q;

  // R11: disabled output carries no data
  always_comb begin
    if (rst_n) a_r11_oe_quiet: assert (!(out_en_n && (rd_data != '0)));
  end
endmodule

// File: tb/dcf_pflag_fifo_tb.sv
`timescale 1ns/1ps
module dcf_pflag_fifo_tb_top;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en1_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full_n, afull_n, empty_n, aempty_n, rd_data_en;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] model_q [$];

  always #5 wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  dcf_pflag_fifo #(.DW(DW), .AW(AW)) dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n), .rd_clk(rd_clk),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n), .rd_data(rd_data),
    .rd_data_en(rd_data_en), .empty_n(empty_n), .aempty_n(aempty_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    #1;
  endtask

  task automatic wr_try(input logic [DW-1:0] d, output bit fired);
    @(negedge wr_clk);
    wr_en1_n = 1'b0; wr_en2_ld = 1'b1; wr_data = d;
    fired = full_n;
    if (fired) model_q.push_back(d);
    @(posedge wr_clk); #1;
    wr_en1_n = 1'b1;
  endtask

  task automatic rd_try(input string req, output bit fired);
    logic [DW-1:0] exp;
    exp = '0;
    @(negedge rd_clk);
    rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    fired = empty_n;
    if (fired) exp = model_q.pop_front();
    @(posedge rd_clk); #1;
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    if (fired) chk(rd_data == exp, req, rd_data, exp);
  endtask

  // R10: flags never read inactive when the condition holds
  initial forever begin
    @(posedge rd_clk); #1;
    if (rst_n && !done && empty_n) chk(model_q.size() > 0, "R10 empty", model_q.size(), 1);
  end
  initial forever begin
    @(posedge wr_clk); #1;
    if (rst_n && !done && full_n) chk(model_q.size() < DEPTH, "R10 full", model_q.size(), DEPTH-1);
  end

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit f;
    logic [DW-1:0] prev;
    repeat (4) @(posedge wr_clk); #1;
    chk(empty_n == 0, "R1 empty_n", empty_n, 0);
    chk(aempty_n == 0, "R1 aempty_n", aempty_n, 0);
    chk(full_n == 1, "R1 full_n", full_n, 1);
    chk(afull_n == 1, "R1 afull_n", afull_n, 1);
    @(negedge wr_clk) rst_n = 1'b1;
    settle();
    chk(empty_n == 0, "R1 empty after release", empty_n, 0);

    // R3: second enable low blocks writes in dual mode
    @(negedge wr_clk); wr_en1_n = 1'b0; wr_en2_ld = 1'b0; wr_data = 9'h055;
    repeat (3) @(negedge wr_clk);
    wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
    settle();
    chk(empty_n == 0, "R3 ignored write", empty_n, 0);

    // R8 R9 default thresholds
    for (int n = 1; n <= DEPTH; n++) begin
      wr_try(DW'(n * 11), f);
      settle();
      chk(aempty_n == (n > 7), "R8 aempty", aempty_n, int'(n > 7));
      chk(afull_n == (n < DEPTH - 7), "R9 afull", afull_n, int'(n < DEPTH - 7));
      chk(full_n == (n < DEPTH), "R5 full flag", full_n, int'(n < DEPTH));
      chk(empty_n == 1, "R10 not empty", empty_n, 1);
    end
    wr_try(9'h1AA, f);
    settle();
    chk(full_n == 0, "R5 still full", full_n, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_try("R7 drain", f);
      chk(f == 1, "R6 read allowed", f, 1);
    end
    settle();
    chk(empty_n == 0, "R5 overflow word not stored", empty_n, 0);
    prev = rd_data;
    rd_try("R6", f);
    settle();
    chk(rd_data == prev, "R6 empty read holds", rd_data, prev);

    // R7 streaming with irregular requests
    fork
      begin
        int i = 0;
        while (i < 40) begin
          if ($urandom % 3 != 0) begin
            wr_try(DW'(i * 7 + 3), f);
            if (f) i++;
          end else @(posedge wr_clk);
        end
      end
      begin
        int k = 0;
        while (k < 40) begin
          if ($urandom % 2 == 0) begin
            rd_try("R7 stream", f);
            if (f) k++;
          end else @(posedge rd_clk);
        end
      end
    join
    settle();
    chk(empty_n == 0, "R7 stream drained", empty_n, 0);

    // R11 output enable
    out_en_n = 1'b1; #1;
    chk(rd_data == 0 && rd_data_en == 0, "R11 disabled", rd_data, 0);
    out_en_n = 1'b0; #1;
    chk(rd_data_en == 1, "R11 enabled", rd_data_en, 1);

    // R2 R4 load mode: offsets 2,3 then wrap to almost-empty=5
    rst_n = 1'b0; wr_en2_ld = 1'b0; model_q.delete();
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk) rst_n = 1'b1;
    settle();
    @(negedge wr_clk); wr_en1_n = 1'b0; wr_data = 9'd2;
    @(negedge wr_clk); wr_data = 9'd3;
    @(negedge wr_clk); wr_data = 9'd5;
    @(negedge wr_clk); wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
    settle();
    chk(empty_n == 0, "R4 load stores no data", empty_n, 0);
    for (int n = 1; n <= 13; n++) begin
      wr_try(DW'(n + 200), f);
      settle();
      if (n == 5 || n == 6) chk(aempty_n == (n > 5), "R4 wrapped ae offset", aempty_n, int'(n > 5));
      if (n == 12 || n == 13) chk(afull_n == (n < 13), "R4 af offset", afull_n, int'(n < 13));
    end
    chk(empty_n == 1, "R2 load mode writes data", empty_n, 1);
    for (int i = 0; i < 13; i++) rd_try("R7 load drain", f);
    settle();
    chk(empty_n == 0, "R7 load drained", empty_n, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule